// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

This block is a synthesizable synchronous SRAM that sits behind one shared data bus and lets reads and writes follow each other on consecutive clocks with no idle cycle between them. Address and control are captured on the rising clock edge. The data of every access, read or write, belongs to the second clock-enabled edge after the command. Because write data lags its command by the same two cycles as read data, a controller can issue any mix of reads and writes back to back, and the bus never needs a turnaround gap.

A single loaded address can be followed by up to three more beats that an internal 2-bit counter generates, in linear or interleaved order. Byte-lane write selects mask individual 9-bit lanes, and a clock-enable input freezes the whole pipeline. Three chip selects start or refuse accesses. The bidirectional bus is modelled as a data-in port, a data-out port and an output-drive flag. The drive flag is gated by an active-low output enable and by the state of the pipeline.

Top module: `zbt_sram`

## Requirements
- R1: After synchronous reset, no access is pending and `dq_drv` is 0 whatever `oe_n` is.
- R2: A command sampled at enabled edge n has its data at enabled edge n+2. For a read, `dq_out` carries the word from after edge n+1 until edge n+2. For a write, `dq_in` is sampled at edge n+2.
- R3: Reads and writes may be issued on consecutive enabled edges in any mix. A read issued right after a write to the same address returns the newly written lanes.
- R4: Lane i is bits [9i+8:9i]. When `lane_wr_n[i]` is 0 at the command edge, a write stores that lane. Lanes with `lane_wr_n[i]` at 1 keep their contents, so a write with all selects at 1 changes nothing.
- R5: While `clk_en_n` is 1 at an edge, every other input is ignored. No command is accepted, no write is done, and all pipeline state and outputs hold.
- R6: With `adv_ld` at 0, an access starts only if `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Here `wr_n`=0 selects a write and `wr_n`=1 a read. Otherwise no access starts and any burst ends, but accesses already in the pipeline still finish.
- R7: With `adv_ld` at 1 during a burst, the next beat is issued on the same upper address bits. Chip selects and `wr_n` are ignored. The read/write type and the order mode stay as latched at the load. The lane selects are sampled again on every beat.
- R8: With `burst_il`=0 at the load, beat k uses low address bits (start + k) mod 4, and the sequence wraps after four beats.
- R9: With `burst_il`=1 at the load, beat k uses low address bits start XOR (k mod 4). Starting from 01, the order is 01,00,11,10.
- R10: `dq_drv` is 1 only in the data window of a read and only while `oe_n` is 0. During a write data window, while deselected, and in the first window after leaving deselect, it is 0 regardless of `oe_n`.
- R11: An advance (`adv_ld`=1) while no burst is active, such as after a deselect or after reset, starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 loads a new address, 1 advances the burst |
| wr_n | input | 1 | 0 write, 1 read, sampled at load |
| lane_wr_n | input | LANES | Active-low per-lane write selects |
| addr | input | ADDR_W | Word address |
| burst_il | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| oe_n | input | 1 | Active-low output enable, combinational |
| dq_in | input | LANES*LANE_W | Write data from the bus |
| dq_out | output | LANES*LANE_W | Read data toward the bus |
| dq_drv | output | 1 | Bus driver enable |

## Verification
The bench goes after a read placed one cycle behind a write to the same word. A design without a forwarding path would return the old word there. It also covers byte writes with sparse and empty lane masks, which catch a design that writes unselected lanes or ignores the selects. Stalls are applied while a write is waiting for its data, with the bus carrying wrong data during the stall. A design that samples data on a disabled edge would store that garbage. Bursts in both orders run past four beats with the chip selects and write enable toggled during advances. A wrong order, a missing wrap, or re-decoding the type mid-burst shows up as wrong read data. Advances after a deselect and reads with output enable high would expose a driver that turns on when it should not.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    // Operation carried down the access pipeline
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    // State of the on-chip burst sequencer
    typedef struct packed {
        logic       active;
        logic       wr;
        logic       interleave;
        logic [1:0] start;
        logic [1:0] step;
    } burst_t;

    localparam burst_t BURST_NONE = '{active: 1'b0, wr: 1'b0, interleave: 1'b0,
                                      start: 2'd0, step: 2'd0};

    // True when all three chip selects are in their active level
    function automatic logic chips_selected(input logic c1_n, input logic c2, input logic c3_n);
        return !c1_n && c2 && !c3_n;
    endfunction

    // Low address bits of a burst beat
    function automatic logic [1:0] burst_lsb(input logic [1:0] start, input logic [1:0] step,
                                             input logic interleave);
        return interleave ? (start ^ step) : (start + step);
    endfunction

endpackage

// File: rtl/zbt_cmd_stage.sv
module zbt_cmd_stage
    import zbt_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic              adv_ld,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              burst_il,
    output op_e               a_op,
    output logic [ADDR_W-1:0] a_addr,
    output logic [LANES-1:0]  a_mask
);

    localparam int HI_W = ADDR_W - 2;

    burst_t          burst;
    logic [HI_W-1:0] base_hi;
    logic            sel;
    logic [1:0]      next_step;

    assign sel       = chips_selected(cs1_n, cs2, cs3_n);
    assign next_step = burst.step + 2'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            burst   <= BURST_NONE;
            base_hi <= '0;
            a_op    <= OP_IDLE;
            a_addr  <= '0;
            a_mask  <= '0;
        end else if (ce) begin
            if (!adv_ld) begin
                if (sel) begin
                    burst.active     <= 1'b1;
                    burst.wr         <= !wr_n;
                    burst.interleave <= burst_il;
                    burst.start      <= addr[1:0];
                    burst.step       <= 2'd0;
                    base_hi          <= addr[ADDR_W-1:2];
                    a_op             <= wr_n ? OP_RD : OP_WR;
                    a_addr           <= addr;
                    a_mask           <= ~lane_wr_n;
                end else begin
                    burst.active <= 1'b0;
                    a_op         <= OP_IDLE;
                end
            end else if (burst.active) begin
                burst.step <= next_step;
                a_op       <= burst.wr ? OP_WR : OP_RD;
                a_addr     <= {base_hi, burst_lsb(burst.start, next_step, burst.interleave)};
                a_mask     <= ~lane_wr_n;
            end else begin
                a_op <= OP_IDLE;
            end
        end
    end

    // R6
    desel_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && !adv_ld && !chips_selected(cs1_n, cs2, cs3_n)) |=> (a_op == OP_IDLE));

    // R11
    orphan_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && adv_ld && !burst.active) |=> (a_op == OP_IDLE));

    // R7
    burst_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && adv_ld && burst.active) |=>
            (a_addr[ADDR_W-1:2] == $past(a_addr[ADDR_W-1:2])) && (a_op == $past(a_op)));

    // R8
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && adv_ld && burst.active && !burst.interleave) |=>
            (a_addr[1:0] == $past(a_addr[1:0]) + 2'd1));

    // R9
    ilv_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && adv_ld && burst.active && burst.interleave) |=>
            (a_addr[0] != $past(a_addr[0])));

endmodule

// File: rtl/zbt_lane_array.sv
module zbt_lane_array #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int ADDR_W = 6
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [LANES-1:0]        wmask,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wmask[l]) begin
                mem[waddr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/zbt_data_stage.sv
module zbt_data_stage
    import zbt_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int ADDR_W = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ce,
    input  op_e                     a_op,
    input  logic [ADDR_W-1:0]       a_addr,
    input  logic [LANES-1:0]        a_mask,
    input  logic [LANES*LANE_W-1:0] rd_word,
    input  logic [LANES*LANE_W-1:0] dq_in,
    input  logic                    oe_n,
    output op_e                     b_op,
    output logic [ADDR_W-1:0]       b_addr,
    output logic [LANES-1:0]        b_mask,
    output logic                    mem_we,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_drv
);

    localparam int DW = LANES * LANE_W;

    logic [DW-1:0] rd_q;
    logic [DW-1:0] fwd_word;
    logic          hit;

    // A write finishing at this edge to the word being read is forwarded
    assign hit = (b_op == OP_WR) && (b_addr == a_addr);

    for (genvar l = 0; l < LANES; l++) begin : g_fwd
        assign fwd_word[l*LANE_W +: LANE_W] = (hit && b_mask[l]) ? dq_in[l*LANE_W +: LANE_W]
                                                                : rd_word[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_op   <= OP_IDLE;
            b_addr <= '0;
            b_mask <= '0;
            rd_q   <= '0;
        end else if (ce) begin
            b_op   <= a_op;
            b_addr <= a_addr;
            b_mask <= a_mask;
            rd_q   <= fwd_word;
        end
    end

    assign mem_we = ce && (b_op == OP_WR);
    assign dq_out = rd_q;
    assign dq_drv = (b_op == OP_RD) && !oe_n;

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(rd_q) && $stable(b_op) && $stable(b_addr)));

    // R2
    stage_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && a_op == OP_WR) |=> (b_op == OP_WR));

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int ADDR_W = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clk_en_n,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    adv_ld,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    burst_il,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_drv
);

    localparam int DW = LANES * LANE_W;

    logic              ce;
    op_e               a_op;
    logic [ADDR_W-1:0] a_addr;
    logic [LANES-1:0]  a_mask;
    op_e               b_op;
    logic [ADDR_W-1:0] b_addr;
    logic [LANES-1:0]  b_mask;
    logic              mem_we;
    logic [DW-1:0]     rd_word;

    assign ce = !clk_en_n;

    zbt_cmd_stage #(.LANES(LANES), .ADDR_W(ADDR_W)) u_cmd (
        .clk(clk), .rst(rst), .ce(ce),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .adv_ld(adv_ld), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
        .addr(addr), .burst_il(burst_il),
        .a_op(a_op), .a_addr(a_addr), .a_mask(a_mask)
    );

    zbt_lane_array #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_array (
        .clk(clk), .we(mem_we), .wmask(b_mask), .waddr(b_addr), .wdata(dq_in),
        .raddr(a_addr), .rdata(rd_word)
    );

    zbt_data_stage #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_data (
        .clk(clk), .rst(rst), .ce(ce),
        .a_op(a_op), .a_addr(a_addr), .a_mask(a_mask),
        .rd_word(rd_word), .dq_in(dq_in), .oe_n(oe_n),
        .b_op(b_op), .b_addr(b_addr), .b_mask(b_mask), .mem_we(mem_we),
        .dq_out(dq_out), .dq_drv(dq_drv)
    );

    // R6
    load_write_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && !adv_ld && chips_selected(cs1_n, cs2, cs3_n) && !wr_n) |=> (a_op == OP_WR));

    // R10
    wr_window_off_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && a_op == OP_WR) |=> !dq_drv);

endmodule

// File: tb/zbt_sram_tb.sv
module zbt_sram_tb_top;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int ADDR_W = 6;
    localparam int DW     = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clk_en_n = 1'b0;
    logic              cs1_n = 1'b1;
    logic              cs2 = 1'b0;
    logic              cs3_n = 1'b1;
    logic              adv_ld = 1'b0;
    logic              wr_n = 1'b1;
    logic [LANES-1:0]  lane_wr_n = '1;
    logic [ADDR_W-1:0] addr = '0;
    logic              burst_il = 1'b0;
    logic              oe_n = 1'b0;
    logic [DW-1:0]     dq_in = '0;
    logic [DW-1:0]     dq_out;
    logic              dq_drv;

    zbt_sram #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .adv_ld(adv_ld), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .addr(addr),
        .burst_il(burst_il), .oe_n(oe_n), .dq_in(dq_in),
        .dq_out(dq_out), .dq_drv(dq_drv)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // Reference model: 0 idle, 1 read, 2 write
    logic [DW-1:0]     ref_mem [DEPTH];
    int                ea_op = 0, eb_op = 0;
    logic [ADDR_W-1:0] ea_addr = '0, eb_addr = '0;
    logic [LANES-1:0]  ea_mask = '0, eb_mask = '0;
    logic [DW-1:0]     ea_wd = '0, eb_wd = '0;
    bit                m_act = 0, m_wr = 0, m_il = 0;
    logic [1:0]        m_start = '0, m_step = '0;
    logic [ADDR_W-3:0] m_hi = '0;
    logic [31:0]       seed = 32'h1234_5678;

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] next_data();
        seed = seed * 32'd1103515245 + 32'd12345;
        return {seed[31:28] ^ 4'h9, seed};
    endfunction

    // One clock: check the window that is ending, drive the next edge, update model
    task automatic cyc(input bit en, input bit adv, input bit c1n, input bit c2, input bit c3n,
                       input bit wrn, input logic [LANES-1:0] lwn, input logic [ADDR_W-1:0] a,
                       input bit il, input bit oen, input string tag);
        bit exp_drv;
        bit sel;
        logic [1:0] lsb;
        @(negedge clk);
        exp_drv = (eb_op == 1) && !oe_n;
        check(dq_drv == exp_drv, tag, {35'd0, dq_drv}, {35'd0, exp_drv});
        if (exp_drv) check(dq_out == ref_mem[eb_addr], tag, dq_out, ref_mem[eb_addr]);
        clk_en_n = !en; adv_ld = adv; cs1_n = c1n; cs2 = c2; cs3_n = c3n;
        wr_n = wrn; lane_wr_n = lwn; addr = a; burst_il = il; oe_n = oen;
        if (eb_op == 2) dq_in = en ? eb_wd : ~eb_wd;
        else            dq_in = 36'h5_A5A5_5A5A;
        @(posedge clk);
        #1;
        if (en) begin
            if (eb_op == 2) begin
                for (int l = 0; l < LANES; l++)
                    if (eb_mask[l]) ref_mem[eb_addr][l*LANE_W +: LANE_W] = eb_wd[l*LANE_W +: LANE_W];
            end
            eb_op = ea_op; eb_addr = ea_addr; eb_mask = ea_mask; eb_wd = ea_wd;
            sel = !c1n && c2 && !c3n;
            if (!adv) begin
                if (sel) begin
                    m_act = 1; m_wr = !wrn; m_il = il; m_start = a[1:0]; m_step = 0;
                    m_hi = a[ADDR_W-1:2];
                    ea_op = wrn ? 1 : 2; ea_addr = a; ea_mask = ~lwn; ea_wd = next_data();
                end else begin
                    m_act = 0; ea_op = 0;
                end
            end else if (m_act) begin
                m_step = m_step + 2'd1;
                lsb = m_il ? (m_start ^ m_step) : (m_start + m_step);
                ea_op = m_wr ? 2 : 1; ea_addr = {m_hi, lsb}; ea_mask = ~lwn; ea_wd = next_data();
            end else begin
                ea_op = 0;
            end
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1, 0, 1, 1, 0, 1, '1, '0, 0, 0, tag);
    endtask
    task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
        cyc(1, 0, 0, 1, 0, 1, '1, a, 0, 0, tag);
    endtask
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [LANES-1:0] lwn, input string tag);
        cyc(1, 0, 0, 1, 0, 0, lwn, a, 0, 0, tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(dq_drv == 1'b0, "R1", {35'd0, dq_drv}, '0);
        idle(1, "R1");
        rd(3, "R1");            // no write has been issued; only the drive flag is inspected
        @(negedge clk);
        check(dq_drv == 1'b0, "R1", {35'd0, dq_drv}, '0);
        ea_op = 0; eb_op = 0;   // discard the unwritten read from the model
        rst = 1'b1; @(posedge clk); #1; rst = 1'b0;
        m_act = 0;
    endtask

    task automatic t_fill();
        for (int a = 0; a < DEPTH; a++) wr(a[ADDR_W-1:0], '0, "R3");
        idle(2, "R3");
    endtask

    task automatic t_single();
        wr(5, '0, "R2"); idle(2, "R2");
        rd(5, "R2"); idle(2, "R2");
    endtask

    task automatic t_mixed();
        wr(9, '0, "R3"); rd(9, "R3"); wr(9, '0, "R3"); rd(9, "R3");
        rd(10, "R3"); wr(10, '0, "R3"); rd(10, "R3"); idle(2, "R3");
    endtask

    task automatic t_lanes();
        wr(12, 4'b1010, "R4"); rd(12, "R4");
        wr(12, 4'b1111, "R4"); rd(12, "R4");
        wr(12, 4'b0111, "R4"); idle(1, "R4"); rd(12, "R4"); idle(2, "R4");
    endtask

    task automatic t_stall();
        rd(20, "R5");
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0, 0, '0, 21, 0, 0, "R5");
        wr(22, '0, "R5"); idle(1, "R5");
        for (int i = 0; i < 2; i++) cyc(0, 1, 0, 1, 0, 0, '0, 22, 0, 0, "R5");
        idle(2, "R5");
        rd(22, "R5"); rd(21, "R5"); idle(2, "R5");
    endtask

    task automatic t_select();
        cyc(1, 0, 1, 1, 0, 0, '0, 30, 0, 0, "R6");
        cyc(1, 0, 0, 0, 0, 0, '0, 30, 0, 0, "R6");
        cyc(1, 0, 0, 1, 1, 0, '0, 30, 0, 0, "R6");
        idle(1, "R6"); rd(30, "R6"); idle(2, "R6");
        wr(33, '0, "R6"); idle(2, "R6"); rd(33, "R6");
        rd(32, "R6"); cyc(1, 1, 1, 1, 0, 0, '0, 0, 0, 0, "R6");
        idle(1, "R6");
        cyc(1, 1, 0, 1, 0, 1, '1, 0, 0, 0, "R11");
        cyc(1, 1, 0, 1, 0, 0, '0, 0, 0, 0, "R11");
        idle(3, "R11");
    endtask

    task automatic t_linear();
        cyc(1, 0, 0, 1, 0, 0, '0, 42, 0, 0, "R8");
        cyc(1, 1, 1, 0, 1, 1, 4'b1100, 0, 1, 0, "R7");
        cyc(1, 1, 1, 1, 0, 1, '0, 0, 1, 0, "R8");
        cyc(1, 1, 0, 1, 0, 1, '0, 0, 1, 0, "R8");
        cyc(1, 1, 1, 1, 1, 1, 4'b0110, 0, 1, 0, "R8");
        idle(2, "R8");
        cyc(1, 0, 0, 1, 0, 1, '1, 41, 0, 0, "R8");
        for (int i = 0; i < 4; i++) cyc(1, 1, 1, 0, 1, 0, '0, 0, 1, 0, "R7");
        idle(2, "R8");
    endtask

    task automatic t_inter();
        cyc(1, 0, 0, 1, 0, 0, '0, 49, 1, 0, "R9");
        for (int i = 0; i < 3; i++) cyc(1, 1, 1, 1, 0, 1, '0, 0, 0, 0, "R9");
        idle(2, "R9");
        cyc(1, 0, 0, 1, 0, 1, '1, 50, 1, 0, "R9");
        for (int i = 0; i < 4; i++) cyc(1, 1, 0, 1, 0, 0, '1, 0, 0, 0, "R9");
        idle(2, "R9");
        for (int a = 48; a < 52; a++) rd(a[ADDR_W-1:0], "R9");
        idle(2, "R9");
    endtask

    task automatic t_oe();
        wr(55, '0, "R10");
        cyc(1, 0, 0, 1, 0, 1, '1, 55, 0, 1, "R10");
        cyc(1, 0, 0, 1, 0, 1, '1, 55, 0, 1, "R10");
        rd(55, "R10");
        wr(56, '0, "R10"); idle(1, "R10");
        rd(56, "R10"); idle(2, "R10");
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_fill();
        t_single();
        t_mixed();
        t_lanes();
        t_stall();
        t_select();
        t_linear();
        t_inter();
        t_oe();
        finished = 1'b1;
        summary();
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

endmodule